// File: doc/BRIEF.md
# Coherent Read Request Sequencer

This block sits at the head of a serialized request queue inside a coherency engine. It takes one read request at a time, always for a single cache line, and walks it through the steps needed before the line's entry can be released. First, if other caches must be snooped, it announces the snoop and counts the responses. Second, it makes sure memory has acknowledged any dirty writeback that this read must not overtake. Third, it issues the memory read if one is still needed. Last, it frees the queue entry.

A dirty snoop response means another cache has pushed fresher data than memory holds. The read is then dropped. The sequencer still waits until memory has acknowledged every writeback caused by those responses. A request with no snoop to do and an older dirty writeback still in flight parks until memory acknowledges that writeback, and only then reads. Because the sequencer accepts nothing new until the current entry is freed, only one read per line is ever in flight.

Top module: `cohreq_seq`

## Requirements
- R1: After reset the sequencer is idle: `hd_accept`, `snp_issue`, `rd_issue` and `entry_free` are all low while `hd_valid` is low.
- R2: A request with `hd_need_snp`=1 is accepted (`hd_accept`=1) in the same cycle that `snp_issue` pulses, and `snp_addr` carries `hd_addr`.
- R3: A request with no snoop, `hd_need_rd`=1 and `older_wb_pend`=0 raises `rd_issue` with its address one cycle after acceptance, then `entry_free` one cycle later.
- R4: A request with no snoop, `hd_need_rd`=1 and `older_wb_pend`=1 issues its read only in the cycle after the next `mem_wr_ack`.
- R5: With snoops needed, the read waits for exactly `hd_snp_num` responses. `rd_issue` rises two cycles after the cycle that carries the last response.
- R6: A snoop response with `snp_rsp_dirty`=1 cancels the read. The entry is freed without `rd_issue`, one cycle after the `mem_wr_ack` that acknowledges the resulting writeback.
- R7: Each dirty response adds one owed write acknowledgement. A `mem_wr_ack` retires one only if one was already owed before that cycle, so an ack in the same cycle as a dirty response does not retire that response's writeback.
- R8: A request that needs neither snoop nor read is freed one cycle after acceptance, whatever `older_wb_pend` is.
- R9: A new head is accepted only when idle. With `hd_valid` held high, back-to-back reads are accepted three cycles apart.
- R10: Snoop responses and write acks that arrive while no owed count or snoop count is open cause no output and change no later timing.
- R11: `entry_free` is a single-cycle pulse, exactly once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd_valid | input | 1 | Queue head holds a request |
| hd_addr | input | ADDR_W | Cache-line address of the head request |
| hd_need_snp | input | 1 | Head request must snoop other caches |
| hd_snp_num | input | CNT_W | Number of snoop responses to expect |
| hd_need_rd | input | 1 | Head request needs a memory read |
| hd_accept | output | 1 | Head request taken this cycle |
| older_wb_pend | input | 1 | An older dirty writeback still awaits memory acknowledgement |
| snp_issue | output | 1 | Pulse: send the snoops for the accepted line |
| snp_addr | output | ADDR_W | Line address for the snoops |
| snp_rsp | input | 1 | One snoop response arrives |
| snp_rsp_dirty | input | 1 | That response carried dirty data (a writeback was sent) |
| mem_wr_ack | input | 1 | Memory acknowledges one writeback |
| rd_issue | output | 1 | Pulse: issue the memory read |
| rd_addr | output | ADDR_W | Line address of the read |
| entry_free | output | 1 | Pulse: release the queue entry |

## Verification
The two events that can fall in one cycle are a dirty snoop response, which opens a new owed write acknowledgement, and a memory write ack, which retires one. The bench drives a dirty response, then a second dirty response together with an ack. It judges the result by when the entry is released: it must come one cycle after a further, separate ack, not straight after the snoops complete. A stray ack during the snoop window, while nothing is owed, is also checked to leave the read timing unchanged.

// File: rtl/cohreq_pkg.sv
`timescale 1ns/1ps
package cohreq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_SNOOP_WAIT = 3'd1,
        ST_WB_WAIT    = 3'd2,
        ST_RD_SEND    = 3'd3,
        ST_RELEASE    = 3'd4
    } seq_state_e;

endpackage

// File: rtl/cohreq_snp_cnt.sv
`timescale 1ns/1ps
// Outstanding snoop response counter for the tracked line.
module cohreq_snp_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             rsp_i,
    output logic             zero_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d.cnt = load_val_i;
        end else if (rsp_i && (cnt_q.cnt != '0)) begin
            cnt_d.cnt = cnt_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q.cnt == '0);

    // R5: an empty counter never wraps on a surplus response
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/cohreq_wb_owed.sv
`timescale 1ns/1ps
// Count of memory write acknowledgements the current request still awaits.
module cohreq_wb_owed #(
    parameter int OWED_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic arm_i,
    input  logic add_i,
    input  logic ack_i,
    output logic zero_o,
    output logic one_o
);

    typedef struct packed {
        logic [OWED_W-1:0] owed;
    } owed_s;

    owed_s owed_d, owed_q;
    logic  retire;

    always_comb begin
        owed_d = owed_q;
        retire = ack_i && (owed_q.owed != '0);
        if (clr_i) begin
            owed_d.owed = arm_i ? OWED_W'(1) : '0;
        end else begin
            unique case ({add_i, retire})
                2'b10:   owed_d.owed = owed_q.owed + OWED_W'(1);
                2'b01:   owed_d.owed = owed_q.owed - OWED_W'(1);
                default: owed_d.owed = owed_q.owed;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else begin
            owed_q <= owed_d;
        end
    end

    assign zero_o = (owed_q.owed == '0);
    assign one_o  = (owed_q.owed == OWED_W'(1));

    // R7: a lone ack against a single owed writeback empties the count
    p_ack_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && ack_i && !add_i && one_o) |=> zero_o);

    // R7: a dirty response and an ack together leave the count unchanged
    p_coincide_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && ack_i && add_i && !zero_o) |=> $stable(owed_q.owed));

endmodule

// File: rtl/cohreq_ctl.sv
`timescale 1ns/1ps
// Per-request step control: snoop, writeback wait, read, release.
module cohreq_ctl
    import cohreq_pkg::*;
#(
    parameter int ADDR_W          = 16,
    parameter bit DIRTY_CANCELS_RD = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd_valid_i,
    input  logic [ADDR_W-1:0] hd_addr_i,
    input  logic              hd_need_snp_i,
    input  logic              hd_need_rd_i,
    input  logic              older_wb_pend_i,
    input  logic              snp_take_i,
    input  logic              snp_dirty_i,
    input  logic              snp_zero_i,
    input  logic              owed_zero_i,
    input  logic              owed_one_i,
    input  logic              wr_ack_i,
    output seq_state_e        state_o,
    output logic              accept_o,
    output logic              cnt_load_o,
    output logic              owed_clr_o,
    output logic              owed_arm_o,
    output logic              rd_issue_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              free_o
);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              rd_need;
    } ctl_s;

    ctl_s ctl_d, ctl_q;
    logic dirty_kill;
    logic owed_clear;

    generate
        if (DIRTY_CANCELS_RD) begin : g_cancel
            assign dirty_kill = snp_take_i && snp_dirty_i;
        end else begin : g_keep
            assign dirty_kill = 1'b0;
        end
    endgenerate

    assign owed_clear = owed_zero_i || (owed_one_i && wr_ack_i);

    always_comb begin
        ctl_d      = ctl_q;
        accept_o   = 1'b0;
        cnt_load_o = 1'b0;
        owed_clr_o = 1'b0;
        owed_arm_o = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (hd_valid_i) begin
                    accept_o      = 1'b1;
                    owed_clr_o    = 1'b1;
                    ctl_d.addr    = hd_addr_i;
                    ctl_d.rd_need = hd_need_rd_i;
                    if (hd_need_snp_i) begin
                        cnt_load_o = 1'b1;
                        ctl_d.st   = ST_SNOOP_WAIT;
                    end else if (hd_need_rd_i && older_wb_pend_i) begin
                        owed_arm_o = 1'b1;
                        ctl_d.st   = ST_WB_WAIT;
                    end else if (hd_need_rd_i) begin
                        ctl_d.st = ST_RD_SEND;
                    end else begin
                        ctl_d.st = ST_RELEASE;
                    end
                end
            end
            ST_SNOOP_WAIT: begin
                if (dirty_kill) begin
                    ctl_d.rd_need = 1'b0;
                end
                if (snp_zero_i) begin
                    if (!owed_zero_i) begin
                        ctl_d.st = ST_WB_WAIT;
                    end else if (ctl_q.rd_need) begin
                        ctl_d.st = ST_RD_SEND;
                    end else begin
                        ctl_d.st = ST_RELEASE;
                    end
                end
            end
            ST_WB_WAIT: begin
                if (owed_clear) begin
                    ctl_d.st = ctl_q.rd_need ? ST_RD_SEND : ST_RELEASE;
                end
            end
            ST_RD_SEND: begin
                ctl_d.st = ST_RELEASE;
            end
            ST_RELEASE: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st      <= ST_IDLE;
            ctl_q.addr    <= '0;
            ctl_q.rd_need <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state_o    = ctl_q.st;
    assign rd_issue_o = (ctl_q.st == ST_RD_SEND);
    assign free_o     = (ctl_q.st == ST_RELEASE);
    assign rd_addr_o  = ctl_q.addr;

    // R8: a request needing neither snoop nor read goes straight to release
    p_direct_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !hd_need_snp_i && !hd_need_rd_i) |=> free_o);

    // R3: the read goes out with the address captured at acceptance
    p_rd_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !hd_need_snp_i && hd_need_rd_i && !older_wb_pend_i)
        |=> (rd_issue_o && rd_addr_o == $past(hd_addr_i)));

endmodule

// File: rtl/cohreq_seq.sv
`timescale 1ns/1ps
module cohreq_seq
    import cohreq_pkg::*;
#(
    parameter int ADDR_W           = 16,
    parameter int CNT_W            = 3,
    parameter bit DIRTY_CANCELS_RD = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd_valid,
    input  logic [ADDR_W-1:0] hd_addr,
    input  logic              hd_need_snp,
    input  logic [CNT_W-1:0]  hd_snp_num,
    input  logic              hd_need_rd,
    output logic              hd_accept,
    input  logic              older_wb_pend,
    output logic              snp_issue,
    output logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_rsp,
    input  logic              snp_rsp_dirty,
    input  logic              mem_wr_ack,
    output logic              rd_issue,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              entry_free
);

    localparam int OWED_W = CNT_W;

    seq_state_e state;
    logic       cnt_load;
    logic       snp_zero;
    logic       snp_take;
    logic       owed_clr;
    logic       owed_arm;
    logic       owed_zero;
    logic       owed_one;

    assign snp_take = (state == ST_SNOOP_WAIT) && snp_rsp && !snp_zero;

    cohreq_snp_cnt #(.CNT_W(CNT_W)) u_snp_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (hd_snp_num),
        .rsp_i      (snp_take),
        .zero_o     (snp_zero)
    );

    cohreq_wb_owed #(.OWED_W(OWED_W)) u_wb_owed (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (owed_clr),
        .arm_i  (owed_arm),
        .add_i  (snp_take && snp_rsp_dirty),
        .ack_i  (mem_wr_ack),
        .zero_o (owed_zero),
        .one_o  (owed_one)
    );

    cohreq_ctl #(
        .ADDR_W           (ADDR_W),
        .DIRTY_CANCELS_RD (DIRTY_CANCELS_RD)
    ) u_ctl (
        .clk             (clk),
        .rst_n           (rst_n),
        .hd_valid_i      (hd_valid),
        .hd_addr_i       (hd_addr),
        .hd_need_snp_i   (hd_need_snp),
        .hd_need_rd_i    (hd_need_rd),
        .older_wb_pend_i (older_wb_pend),
        .snp_take_i      (snp_take),
        .snp_dirty_i     (snp_rsp_dirty),
        .snp_zero_i      (snp_zero),
        .owed_zero_i     (owed_zero),
        .owed_one_i      (owed_one),
        .wr_ack_i        (mem_wr_ack),
        .state_o         (state),
        .accept_o        (hd_accept),
        .cnt_load_o      (cnt_load),
        .owed_clr_o      (owed_clr),
        .owed_arm_o      (owed_arm),
        .rd_issue_o      (rd_issue),
        .rd_addr_o       (rd_addr),
        .free_o          (entry_free)
    );

    assign snp_issue = hd_accept && hd_need_snp;
    assign snp_addr  = hd_addr;

    // R5: no read leaves while snoop responses are still outstanding
    p_rd_after_snoops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |-> snp_zero);

    // R4: no read leaves while a write acknowledgement is still owed
    p_rd_owed_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |-> owed_zero);

    // R3: a read is always followed by the entry release
    p_rd_then_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |=> entry_free);

    // R11: the release is a single-cycle pulse
    p_free_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        entry_free |=> !entry_free);

    // R9: after acceptance the head is not taken again next cycle
    p_busy_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hd_accept |=> !hd_accept);

endmodule

// File: tb/tb_cohreq_seq.sv
`timescale 1ns/1ps
module tb_cohreq_seq;

    localparam int AW = 16;
    localparam int CW = 3;
    localparam int EV_SNP  = 0;
    localparam int EV_RD   = 1;
    localparam int EV_FREE = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hd_valid = 1'b0;
    logic [AW-1:0] hd_addr = '0;
    logic          hd_need_snp = 1'b0;
    logic [CW-1:0] hd_snp_num = '0;
    logic          hd_need_rd = 1'b0;
    logic          hd_accept;
    logic          older_wb_pend = 1'b0;
    logic          snp_issue;
    logic [AW-1:0] snp_addr;
    logic          snp_rsp = 1'b0;
    logic          snp_rsp_dirty = 1'b0;
    logic          mem_wr_ack = 1'b0;
    logic          rd_issue;
    logic [AW-1:0] rd_addr;
    logic          entry_free;

    always #2.5 clk = ~clk;

    cohreq_seq #(.ADDR_W(AW), .CNT_W(CW)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .hd_valid      (hd_valid),
        .hd_addr       (hd_addr),
        .hd_need_snp   (hd_need_snp),
        .hd_snp_num    (hd_snp_num),
        .hd_need_rd    (hd_need_rd),
        .hd_accept     (hd_accept),
        .older_wb_pend (older_wb_pend),
        .snp_issue     (snp_issue),
        .snp_addr      (snp_addr),
        .snp_rsp       (snp_rsp),
        .snp_rsp_dirty (snp_rsp_dirty),
        .mem_wr_ack    (mem_wr_ack),
        .rd_issue      (rd_issue),
        .rd_addr       (rd_addr),
        .entry_free    (entry_free)
    );

    typedef struct {
        int            kind;
        logic [AW-1:0] addr;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   n_free = 0;
    int   t_acc = 0, t_snp = 0, t_rd = 0, t_free = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic expect_ev(input int kind, input logic [AW-1:0] a, input string req);
        exp_t e;
        e.kind = kind;
        e.addr = a;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    task automatic sb(input int kind, input logic [AW-1:0] a);
        exp_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R10/R11", "unexpected event kind", kind, -1);
        end else begin
            e = exp_q.pop_front();
            chk(e.kind == kind, e.req, "event kind", kind, e.kind);
            if (kind != EV_FREE) begin
                chk(a == e.addr, e.req, "event address", int'(a), int'(e.addr));
            end
        end
    endtask

    // Monitor: samples away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (hd_accept) t_acc = cyc;
            if (snp_issue) begin t_snp = cyc; sb(EV_SNP, snp_addr); end
            if (rd_issue)  begin t_rd  = cyc; sb(EV_RD, rd_addr); end
            if (entry_free) begin t_free = cyc; n_free++; sb(EV_FREE, '0); end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic offer(input logic [AW-1:0] a, input bit snp, input int nsnp,
                         input bit rd);
        hd_valid    = 1'b1;
        hd_addr     = a;
        hd_need_snp = snp;
        hd_snp_num  = CW'(nsnp);
        hd_need_rd  = rd;
        do @(negedge clk); while (!hd_accept);
        @(posedge clk);
        #1;
        hd_valid    = 1'b0;
        hd_need_snp = 1'b0;
        hd_need_rd  = 1'b0;
    endtask

    task automatic pulse(input bit rsp, input bit dirty, input bit ack);
        snp_rsp       = rsp;
        snp_rsp_dirty = dirty;
        mem_wr_ack    = ack;
        tick(1);
        snp_rsp       = 1'b0;
        snp_rsp_dirty = 1'b0;
        mem_wr_ack    = 1'b0;
    endtask

    task automatic wait_free(input int target);
        while (n_free < target) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic drained(input string req);
        chk(exp_q.size() == 0, req, "expected events left over", exp_q.size(), 0);
    endtask

    initial begin
        int nf0;
        int mark;
        int t1;
        int t2;
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk(!hd_accept && !snp_issue && !rd_issue && !entry_free, "R1",
            "outputs after reset", int'({hd_accept, snp_issue, rd_issue, entry_free}), 0);
        @(posedge clk);
        #1;

        // R10: stray dirty responses and acks while idle
        snp_rsp = 1'b1; snp_rsp_dirty = 1'b1; mem_wr_ack = 1'b1;
        tick(2);
        snp_rsp = 1'b0; snp_rsp_dirty = 1'b0; mem_wr_ack = 1'b0;
        tick(1);

        // R3 plain read (also shows R10 left nothing armed)
        nf0 = n_free;
        expect_ev(EV_RD, 16'h0100, "R3");
        expect_ev(EV_FREE, 16'h0100, "R3");
        offer(16'h0100, 1'b0, 0, 1'b1);
        wait_free(nf0 + 1);
        chk(t_rd == t_acc + 1, "R3/R10", "read cycle after accept", t_rd - t_acc, 1);
        chk(t_free == t_rd + 1, "R3", "release after read", t_free - t_rd, 1);
        drained("R3");

        // R8 nothing to do, older writeback pending is irrelevant
        nf0 = n_free;
        expect_ev(EV_FREE, 16'h0200, "R8");
        older_wb_pend = 1'b1;
        offer(16'h0200, 1'b0, 0, 1'b0);
        wait_free(nf0 + 1);
        older_wb_pend = 1'b0;
        chk(t_free == t_acc + 1, "R8", "release after accept", t_free - t_acc, 1);
        drained("R8");

        // R4 read held behind an older writeback
        nf0 = n_free;
        expect_ev(EV_RD, 16'h0300, "R4");
        expect_ev(EV_FREE, 16'h0300, "R4");
        older_wb_pend = 1'b1;
        offer(16'h0300, 1'b0, 0, 1'b1);
        tick(4);
        older_wb_pend = 1'b0;
        mark = cyc;
        pulse(1'b0, 1'b0, 1'b1);
        wait_free(nf0 + 1);
        chk(t_rd == mark + 1, "R4", "read cycle relative to ack", t_rd - mark, 1);
        drained("R4");

        // R2/R5 three clean snoops, stray ack in between
        nf0 = n_free;
        expect_ev(EV_SNP, 16'h0400, "R2");
        expect_ev(EV_RD, 16'h0400, "R5");
        expect_ev(EV_FREE, 16'h0400, "R5");
        offer(16'h0400, 1'b1, 3, 1'b1);
        chk(t_snp == t_acc, "R2", "snoop pulse vs accept", t_snp - t_acc, 0);
        pulse(1'b1, 1'b0, 1'b0);
        pulse(1'b0, 1'b0, 1'b1);
        pulse(1'b1, 1'b0, 1'b0);
        tick(1);
        mark = cyc;
        pulse(1'b1, 1'b0, 1'b0);
        wait_free(nf0 + 1);
        chk(t_rd == mark + 2, "R5/R10", "read after last response", t_rd - mark, 2);
        drained("R5");

        // R6 dirty response cancels the read, release waits for the ack
        nf0 = n_free;
        expect_ev(EV_SNP, 16'h0500, "R6");
        expect_ev(EV_FREE, 16'h0500, "R6");
        offer(16'h0500, 1'b1, 2, 1'b1);
        pulse(1'b1, 1'b0, 1'b0);
        pulse(1'b1, 1'b1, 1'b0);
        tick(5);
        chk(n_free == nf0, "R6", "released before write ack", n_free - nf0, 0);
        mark = cyc;
        pulse(1'b0, 1'b0, 1'b1);
        wait_free(nf0 + 1);
        chk(t_free == mark + 1, "R6", "release relative to ack", t_free - mark, 1);
        drained("R6");

        // R7 dirty response coinciding with an ack
        nf0 = n_free;
        expect_ev(EV_SNP, 16'h0600, "R7");
        expect_ev(EV_FREE, 16'h0600, "R7");
        offer(16'h0600, 1'b1, 2, 1'b1);
        pulse(1'b1, 1'b1, 1'b0);
        pulse(1'b1, 1'b1, 1'b1);
        tick(5);
        chk(n_free == nf0, "R7", "released with an ack still owed", n_free - nf0, 0);
        mark = cyc;
        pulse(1'b0, 1'b0, 1'b1);
        wait_free(nf0 + 1);
        chk(t_free == mark + 1, "R7", "release relative to final ack", t_free - mark, 1);
        drained("R7");

        // R9/R11 back-to-back heads with valid held
        nf0 = n_free;
        expect_ev(EV_RD, 16'h0700, "R9");
        expect_ev(EV_FREE, 16'h0700, "R9");
        expect_ev(EV_RD, 16'h0701, "R9");
        expect_ev(EV_FREE, 16'h0701, "R9");
        hd_valid = 1'b1; hd_addr = 16'h0700; hd_need_rd = 1'b1;
        do @(negedge clk); while (!hd_accept);
        t1 = cyc;
        @(posedge clk);
        #1;
        hd_addr = 16'h0701;
        do @(negedge clk); while (!hd_accept);
        t2 = cyc;
        @(posedge clk);
        #1;
        hd_valid = 1'b0; hd_need_rd = 1'b0;
        wait_free(nf0 + 2);
        tick(3);
        chk(t2 == t1 + 3, "R9", "accept spacing", t2 - t1, 3);
        chk(n_free == nf0 + 2, "R11", "release pulses for two requests", n_free - nf0, 2);
        drained("R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule